// File: doc/BRIEF.md
# Double-to-Single Precision Rounding Unit

This unit narrows a 64-bit IEEE 754 double operand to single precision. It returns the result in two forms: a 32-bit single encoding, and a 64-bit image that holds the same value written exactly as a double. A 2-bit mode input selects the rounding direction. The unit sorts each operand into one of seven classes: zero, tiny, normal, huge, infinity, quiet NaN or signaling NaN. Operands in the tiny class are first shifted down to the smallest single exponent. The shift keeps guard, round and sticky bits, and the rounding step works on that shifted value.

The unit reports five status conditions: underflow, overflow, inexact, fraction-incremented and invalid. It also ORs its inexact indication into an accumulated-inexact input and returns the result, and it raises a trap request when an enabled condition occurs. An enabled underflow or overflow returns the same result as the disabled case. Exponent wrapping and the register write are left to the surrounding pipeline. Each accepted operand produces its result one clock later.

Top module: `dp2sp_round_unit`

## Requirements
- R1: A result appears on the outputs one clock after `valid_i` is sampled high, and `valid_o` follows `valid_i` with one cycle of delay. Reset clears every output to zero.
- R2: Operands with a biased exponent from 897 to 1150 are rounded to 24 significant bits. The modes are 00 nearest-even, 01 toward zero, 10 toward +infinity and 11 toward -infinity. Nearest-even treats input fraction bit 28 as the half bit and the OR of every lower bit as sticky. On an exact tie it keeps an even last bit.
- R3: `inexact_o` is set when any bit below the kept 24 is nonzero. `frac_rnd_o` is set when a finite result was rounded up in magnitude.
- R4: If rounding carries a normal operand past the largest single exponent, the operand is handled as an overflow.
- R5: A biased exponent from 1151 to 2046, or a rounding carry as in R4, sets `oflow_o` and `inexact_o`. The result is infinity in nearest-even mode and in the mode that rounds toward the operand's sign. In the other two modes the result is the largest finite single of that sign.
- R6: A nonzero operand with a biased exponent below 897 is shifted right to exponent -126. The shift keeps guard and round bits and folds all other shifted-out bits into sticky, and the result is then rounded by R2. This yields a single denormal, zero, or the smallest normal.
- R7: For such a tiny operand, `uflow_o` is set when the value is inexact. When `ue_en_i` is high, `uflow_o` is set for every tiny operand.
- R8: Signed zeros and signed infinities are returned unchanged in value, with no flags set.
- R9: A quiet NaN (exponent all ones, fraction bit 51 set) keeps its sign and the upper 23 fraction bits, and sets no flag.
- R10: A signaling NaN (exponent all ones, fraction bit 51 clear, rest nonzero) sets `invalid_o`. It is returned with fraction bit 51 forced to one.
- R11: `xx_o` equals `xx_i` ORed with this operation's inexact indication.
- R12: `trap_o` is set when at least one of these holds: underflow with `ue_en_i`, overflow with `oe_en_i`, invalid with `ve_en_i`, or inexact with `xe_en_i`.
- R13: `res64_o` is the exact double encoding of the value in `res32_o`. A single denormal appears there as a normalized double.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand valid |
| op_i | input | 64 | Double operand |
| rmode_i | input | 2 | Rounding mode |
| ue_en_i | input | 1 | Underflow trap enable |
| oe_en_i | input | 1 | Overflow trap enable |
| ve_en_i | input | 1 | Invalid trap enable |
| xe_en_i | input | 1 | Inexact trap enable |
| xx_i | input | 1 | Accumulated inexact in |
| valid_o | output | 1 | Result valid |
| res64_o | output | 64 | Result as double image |
| res32_o | output | 32 | Result as single |
| uflow_o | output | 1 | Underflow |
| oflow_o | output | 1 | Overflow |
| inexact_o | output | 1 | Result inexact |
| frac_rnd_o | output | 1 | Magnitude rounded up |
| invalid_o | output | 1 | Signaling NaN seen |
| xx_o | output | 1 | Accumulated inexact out |
| trap_o | output | 1 | Enabled exception request |

## Verification
Two events can land on the same operand: the denormalizing shift and a rounding carry that lifts the value into the normal range. One operand sits just below 2^-126, and its shifted fraction of all ones plus a set half bit must round up to the smallest normal single. The bench checks that this operand still raises the underflow flag, and it checks the same operand under truncation, where the result must stay denormal. In the normal range, the largest double exponent that still counts as normal, with an all-ones fraction, forces a carry and an overflow together. That case is checked for infinity in nearest-even mode and for the largest finite value under truncation.

// File: rtl/dp2sp_pkg.sv
package dp2sp_pkg;
  localparam int unsigned DP_W      = 64;
  localparam int unsigned DP_EXP_W  = 11;
  localparam int unsigned DP_FRAC_W = 52;
  localparam int unsigned SIG_W     = DP_FRAC_W + 1;
  localparam int unsigned SP_W      = 32;
  localparam int unsigned SP_EXP_W  = 8;
  localparam int unsigned SP_FRAC_W = 23;
  localparam int unsigned SP_SIG_W  = SP_FRAC_W + 1;
  localparam int unsigned GRS_W     = 3;
  localparam int unsigned EXP_W     = 13;
  localparam int unsigned LZ_W      = $clog2(SP_SIG_W);

  localparam logic [DP_EXP_W-1:0] TINY_LIM = 11'd897;
  localparam logic [DP_EXP_W-1:0] HUGE_LIM = 11'd1150;
  localparam logic signed [EXP_W-1:0] DP_BIAS_S = 13'sd1023;
  localparam logic signed [EXP_W-1:0] SP_BIAS_S = 13'sd127;
  localparam logic signed [EXP_W-1:0] SP_EMIN_S = -13'sd126;
  localparam logic signed [EXP_W-1:0] SP_EMAX_S = 13'sd127;
  localparam logic signed [EXP_W-1:0] DP_EMIN_S = -13'sd1022;

  typedef enum logic [2:0] {
    CL_ZERO, CL_TINY, CL_NORM, CL_HUGE, CL_INF, CL_QNAN, CL_SNAN
  } op_class_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00, RM_ZERO = 2'b01, RM_PINF = 2'b10, RM_NINF = 2'b11
  } rmode_e;

  typedef struct packed {
    logic                    sign;
    logic signed [EXP_W-1:0] exp;
    logic [SIG_W-1:0]        sig;
  } unpk_t;

  function automatic logic [LZ_W-1:0] lzc_sp(input logic [SP_SIG_W-1:0] v);
    logic [LZ_W-1:0] n;
    logic            hit;
    n   = '0;
    hit = 1'b0;
    for (int i = SP_SIG_W - 1; i >= 0; i--) begin
      if (!hit && v[i]) hit = 1'b1;
      else if (!hit) n = n + 1'b1;
    end
    return n;
  endfunction
endpackage

// File: rtl/dp2sp_classify.sv
module dp2sp_classify
  import dp2sp_pkg::*;
(
  input  logic [DP_W-1:0] op_i,
  output op_class_e       cls_o,
  output unpk_t           unpk_o
);
  logic [DP_EXP_W-1:0]  bexp;
  logic [DP_FRAC_W-1:0] frac;
  logic                 mag_nz;

  assign bexp   = op_i[DP_W-2 -: DP_EXP_W];
  assign frac   = op_i[DP_FRAC_W-1:0];
  assign mag_nz = |op_i[DP_W-2:0];

  always_comb begin
    if (&bexp) begin
      if (frac == '0)          cls_o = CL_INF;
      else if (frac[DP_FRAC_W-1]) cls_o = CL_QNAN;
      else                     cls_o = CL_SNAN;
    end else if (!mag_nz)      cls_o = CL_ZERO;
    else if (bexp < TINY_LIM)  cls_o = CL_TINY;
    else if (bexp > HUGE_LIM)  cls_o = CL_HUGE;
    else                       cls_o = CL_NORM;
  end

  always_comb begin
    unpk_o.sign = op_i[DP_W-1];
    if (bexp == '0) begin
      unpk_o.exp = DP_EMIN_S;
      unpk_o.sig = {1'b0, frac};
    end else begin
      unpk_o.exp = $signed({2'b00, bexp}) - DP_BIAS_S;
      unpk_o.sig = {1'b1, frac};
    end
  end
endmodule

// File: rtl/dp2sp_denorm.sv
module dp2sp_denorm
  import dp2sp_pkg::*;
#(
  parameter int unsigned VW   = SIG_W + GRS_W,
  parameter int unsigned SH_W = $clog2(VW)
) (
  input  logic                    tiny_i,
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic [SIG_W-1:0]        sig_i,
  output logic signed [EXP_W-1:0] exp_o,
  output logic [SIG_W-1:0]        sig_o,
  output logic                    g_o,
  output logic                    r_o,
  output logic                    x_o
);
  localparam logic signed [EXP_W-1:0] SH_MAX = EXP_W'((1 << SH_W) - 1);

  logic signed [EXP_W-1:0] diff;
  logic [SH_W-1:0]         sh;
  logic [VW-1:0]           stg [0:SH_W];

  assign diff  = SP_EMIN_S - exp_i;
  assign sh    = !tiny_i ? '0 : (diff > SH_MAX) ? SH_MAX[SH_W-1:0] : diff[SH_W-1:0];
  assign exp_o = tiny_i ? SP_EMIN_S : exp_i;
  assign stg[0] = {sig_i, {GRS_W{1'b0}}};

  // each stage shifts by 2^k and folds the lost bits into the sticky lsb
  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int unsigned A = 1 << k;
    if (A < VW) begin : g_sh
      assign stg[k+1] = sh[k]
        ? ({{A{1'b0}}, stg[k][VW-1:A]} | {{(VW-1){1'b0}}, |stg[k][A-1:0]})
        : stg[k];
    end else begin : g_all
      assign stg[k+1] = sh[k] ? {{(VW-1){1'b0}}, |stg[k]} : stg[k];
    end
  end

  assign sig_o = stg[SH_W][VW-1:GRS_W];
  assign g_o   = stg[SH_W][2];
  assign r_o   = stg[SH_W][1];
  assign x_o   = stg[SH_W][0];
endmodule

// File: rtl/dp2sp_round.sv
module dp2sp_round
  import dp2sp_pkg::*;
(
  input  logic                    sign_i,
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic [SIG_W-1:0]        sig_i,
  input  logic                    g_i,
  input  logic                    r_i,
  input  logic                    x_i,
  input  rmode_e                  rmode_i,
  output logic [SP_SIG_W-1:0]     sig_o,
  output logic signed [EXP_W-1:0] exp_o,
  output logic                    lost_o,
  output logic                    inc_o,
  output logic                    ovf_o
);
  localparam int unsigned CUT = SIG_W - SP_SIG_W;

  logic [SP_SIG_W-1:0] keep;
  logic [SP_SIG_W:0]   sum;
  logic                half, low;

  assign keep   = sig_i[SIG_W-1:CUT];
  assign half   = sig_i[CUT-1];
  assign low    = (|sig_i[CUT-2:0]) | g_i | r_i | x_i;
  assign lost_o = half | low;

  always_comb begin
    unique case (rmode_i)
      RM_NEAR: inc_o = half & (low | keep[0]);
      RM_ZERO: inc_o = 1'b0;
      RM_PINF: inc_o = !sign_i && lost_o;
      RM_NINF: inc_o = sign_i && lost_o;
      default: inc_o = 1'b0;
    endcase
  end

  assign sum = {1'b0, keep} + {{SP_SIG_W{1'b0}}, inc_o};

  always_comb begin
    if (sum[SP_SIG_W]) begin
      sig_o = {1'b1, {(SP_SIG_W-1){1'b0}}};
      exp_o = exp_i + 13'sd1;
    end else begin
      sig_o = sum[SP_SIG_W-1:0];
      exp_o = exp_i;
    end
  end

  assign ovf_o = exp_o > SP_EMAX_S;
endmodule

// File: rtl/dp2sp_pack.sv
module dp2sp_pack
  import dp2sp_pkg::*;
(
  input  op_class_e               cls_i,
  input  logic                    sign_i,
  input  logic                    ovf_i,
  input  rmode_e                  rmode_i,
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic [SP_SIG_W-1:0]     sig_i,
  input  logic [SP_FRAC_W-1:0]    nan_frac_i,
  output logic [SP_W-1:0]         res32_o,
  output logic [DP_W-1:0]         res64_o
);
  localparam logic [SP_FRAC_W-1:0] QBIT = {1'b1, {(SP_FRAC_W-1){1'b0}}};
  localparam int unsigned PAD = DP_FRAC_W - SP_FRAC_W;

  logic                    use_inf;
  logic [LZ_W-1:0]         lz;
  logic [SP_SIG_W-1:0]     norm;
  logic signed [EXP_W-1:0] e32, e64;
  logic [SP_FRAC_W-1:0]    qfrac;
  logic [SP_W-1:0]         fin32, ovf32;
  logic [DP_W-1:0]         fin64, ovf64;

  assign use_inf = (rmode_i == RM_NEAR) || (rmode_i == RM_PINF && !sign_i) ||
                   (rmode_i == RM_NINF && sign_i);
  assign lz    = lzc_sp(sig_i);
  assign norm  = sig_i << lz;
  assign e32   = exp_i + SP_BIAS_S;
  assign e64   = exp_i - $signed({{(EXP_W-LZ_W){1'b0}}, lz}) + DP_BIAS_S;
  assign qfrac = nan_frac_i | QBIT;

  always_comb begin
    if (sig_i == '0) begin
      fin32 = {sign_i, {(SP_W-1){1'b0}}};
      fin64 = {sign_i, {(DP_W-1){1'b0}}};
    end else begin
      fin32 = {sign_i, sig_i[SP_SIG_W-1] ? e32[SP_EXP_W-1:0] : {SP_EXP_W{1'b0}},
               sig_i[SP_FRAC_W-1:0]};
      fin64 = {sign_i, e64[DP_EXP_W-1:0], norm[SP_FRAC_W-1:0], {PAD{1'b0}}};
    end
    if (use_inf) begin
      ovf32 = {sign_i, {SP_EXP_W{1'b1}}, {SP_FRAC_W{1'b0}}};
      ovf64 = {sign_i, {DP_EXP_W{1'b1}}, {DP_FRAC_W{1'b0}}};
    end else begin
      ovf32 = {sign_i, {(SP_EXP_W-1){1'b1}}, 1'b0, {SP_FRAC_W{1'b1}}};
      ovf64 = {sign_i, 11'h47E, {SP_FRAC_W{1'b1}}, {PAD{1'b0}}};
    end
  end

  always_comb begin
    unique case (cls_i)
      CL_ZERO: begin
        res32_o = {sign_i, {(SP_W-1){1'b0}}};
        res64_o = {sign_i, {(DP_W-1){1'b0}}};
      end
      CL_INF: begin
        res32_o = {sign_i, {SP_EXP_W{1'b1}}, {SP_FRAC_W{1'b0}}};
        res64_o = {sign_i, {DP_EXP_W{1'b1}}, {DP_FRAC_W{1'b0}}};
      end
      CL_QNAN, CL_SNAN: begin
        res32_o = {sign_i, {SP_EXP_W{1'b1}}, qfrac};
        res64_o = {sign_i, {DP_EXP_W{1'b1}}, qfrac, {PAD{1'b0}}};
      end
      default: begin
        res32_o = ovf_i ? ovf32 : fin32;
        res64_o = ovf_i ? ovf64 : fin64;
      end
    endcase
  end
endmodule

// File: rtl/dp2sp_round_unit.sv
module dp2sp_round_unit
  import dp2sp_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [DP_W-1:0] op_i,
  input  logic [1:0]      rmode_i,
  input  logic            ue_en_i,
  input  logic            oe_en_i,
  input  logic            ve_en_i,
  input  logic            xe_en_i,
  input  logic            xx_i,
  output logic            valid_o,
  output logic [DP_W-1:0] res64_o,
  output logic [SP_W-1:0] res32_o,
  output logic            uflow_o,
  output logic            oflow_o,
  output logic            inexact_o,
  output logic            frac_rnd_o,
  output logic            invalid_o,
  output logic            xx_o,
  output logic            trap_o
);
  op_class_e               cls;
  unpk_t                   unpk;
  rmode_e                  rm;
  logic signed [EXP_W-1:0] dn_exp, rd_exp;
  logic [SIG_W-1:0]        dn_sig;
  logic                    dn_g, dn_r, dn_x;
  logic [SP_SIG_W-1:0]     rd_sig;
  logic                    lost, inc, rd_ovf;
  logic                    finite, ovf_any, nx, fr, uf, inv, trp;
  logic [SP_W-1:0]         r32;
  logic [DP_W-1:0]         r64;

  assign rm = rmode_e'(rmode_i);

  dp2sp_classify u_cls (.op_i(op_i), .cls_o(cls), .unpk_o(unpk));

  dp2sp_denorm u_dn (
    .tiny_i(cls == CL_TINY), .exp_i(unpk.exp), .sig_i(unpk.sig),
    .exp_o(dn_exp), .sig_o(dn_sig), .g_o(dn_g), .r_o(dn_r), .x_o(dn_x)
  );

  dp2sp_round u_rnd (
    .sign_i(unpk.sign), .exp_i(dn_exp), .sig_i(dn_sig),
    .g_i(dn_g), .r_i(dn_r), .x_i(dn_x), .rmode_i(rm),
    .sig_o(rd_sig), .exp_o(rd_exp), .lost_o(lost), .inc_o(inc), .ovf_o(rd_ovf)
  );

  assign finite  = (cls == CL_NORM) || (cls == CL_TINY);
  assign ovf_any = (cls == CL_HUGE) || ((cls == CL_NORM) && rd_ovf);
  assign nx      = ovf_any || (finite && lost);
  assign fr      = finite && inc && !ovf_any;
  assign uf      = (cls == CL_TINY) && (ue_en_i || lost);
  assign inv     = (cls == CL_SNAN);
  assign trp     = (ue_en_i && uf) || (oe_en_i && ovf_any) ||
                   (ve_en_i && inv) || (xe_en_i && nx);

  dp2sp_pack u_pack (
    .cls_i(cls), .sign_i(unpk.sign), .ovf_i(ovf_any), .rmode_i(rm),
    .exp_i(rd_exp), .sig_i(rd_sig), .nan_frac_i(op_i[DP_FRAC_W-1 -: SP_FRAC_W]),
    .res32_o(r32), .res64_o(r64)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      res64_o    <= '0;
      res32_o    <= '0;
      uflow_o    <= 1'b0;
      oflow_o    <= 1'b0;
      inexact_o  <= 1'b0;
      frac_rnd_o <= 1'b0;
      invalid_o  <= 1'b0;
      xx_o       <= 1'b0;
      trap_o     <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res64_o    <= r64;
        res32_o    <= r32;
        uflow_o    <= uf;
        oflow_o    <= ovf_any;
        inexact_o  <= nx;
        frac_rnd_o <= fr;
        invalid_o  <= inv;
        xx_o       <= xx_i || nx;
        trap_o     <= trp;
      end
    end
  end

  p_valid_hi_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_valid_lo_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_fr_inexact_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frac_rnd_o |-> inexact_o);
  p_ovf_inexact_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oflow_o |-> (inexact_o && !uflow_o && res32_o[30:23] >= 8'hFE));
  p_nan_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> (res32_o[30:22] == 9'h1FF && res64_o[62:51] == 12'hFFF));
  p_xx_cover_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inexact_o |-> xx_o);
  p_trap_cause_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (uflow_o || oflow_o || invalid_o || inexact_o));
  p_sign_match_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (res32_o[31] == res64_o[63]));
endmodule

// File: tb/dp2sp_round_unit_test.sv
`timescale 1ns/1ps
module dp2sp_round_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] op_i = '0;
  logic [1:0]  rmode_i = '0;
  logic        ue_en_i = 1'b0, oe_en_i = 1'b0, ve_en_i = 1'b0, xe_en_i = 1'b0;
  logic        xx_i = 1'b0;
  logic        valid_o;
  logic [63:0] res64_o;
  logic [31:0] res32_o;
  logic        uflow_o, oflow_o, inexact_o, frac_rnd_o, invalid_o, xx_o, trap_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  dp2sp_round_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i), .rmode_i(rmode_i),
    .ue_en_i(ue_en_i), .oe_en_i(oe_en_i), .ve_en_i(ve_en_i), .xe_en_i(xe_en_i),
    .xx_i(xx_i), .valid_o(valid_o), .res64_o(res64_o), .res32_o(res32_o),
    .uflow_o(uflow_o), .oflow_o(oflow_o), .inexact_o(inexact_o),
    .frac_rnd_o(frac_rnd_o), .invalid_o(invalid_o), .xx_o(xx_o), .trap_o(trap_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run exceeded cycle limit");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  // flags packed as {uflow, oflow, inexact, frac_rnd, invalid, xx, trap}
  task automatic run(input string req, input logic [63:0] op, input logic [1:0] rm,
                     input logic [3:0] en, input logic xxi,
                     input logic [31:0] e32, input logic [63:0] e64, input logic [6:0] efl);
    @(negedge clk);
    op_i = op; rmode_i = rm; xx_i = xxi;
    {ue_en_i, oe_en_i, ve_en_i, xe_en_i} = en;
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    chk({req, " valid R1"}, {63'b0, valid_o}, 64'd1);
    chk({req, " res32"}, {32'b0, res32_o}, {32'b0, e32});
    chk({req, " res64 R13"}, res64_o, e64);
    chk({req, " flags"}, {57'b0, uflow_o, oflow_o, inexact_o, frac_rnd_o, invalid_o, xx_o, trap_o},
        {57'b0, efl});
  endtask

  task automatic t_reset;
    chk("R1 reset valid", {63'b0, valid_o}, 64'd0);
    chk("R1 reset res64", res64_o, 64'd0);
    chk("R1 reset flags", {57'b0, uflow_o, oflow_o, inexact_o, frac_rnd_o, invalid_o, xx_o, trap_o}, 64'd0);
  endtask

  task automatic t_round_modes;
    run("R2 one", 64'h3FF0000000000000, 2'b00, 4'b0, 1'b0, 32'h3F800000, 64'h3FF0000000000000, 7'b0000000);
    @(negedge clk);
    chk("R1 valid drops", {63'b0, valid_o}, 64'd0);
    run("R2 tie even near", 64'h3FF0000010000000, 2'b00, 4'b0, 1'b0, 32'h3F800000, 64'h3FF0000000000000, 7'b0010010);
    run("R3 tie +inf", 64'h3FF0000010000000, 2'b10, 4'b0, 1'b0, 32'h3F800001, 64'h3FF0000020000000, 7'b0011010);
    run("R2 tie zero", 64'h3FF0000010000000, 2'b01, 4'b0, 1'b0, 32'h3F800000, 64'h3FF0000000000000, 7'b0010010);
    run("R2 tie -inf pos", 64'h3FF0000010000000, 2'b11, 4'b0, 1'b0, 32'h3F800000, 64'h3FF0000000000000, 7'b0010010);
    run("R2 neg -inf", 64'hBFF0000010000000, 2'b11, 4'b0, 1'b0, 32'hBF800001, 64'hBFF0000020000000, 7'b0011010);
    run("R2 neg +inf", 64'hBFF0000010000000, 2'b10, 4'b0, 1'b0, 32'hBF800000, 64'hBFF0000000000000, 7'b0010010);
    run("R2 tie odd near", 64'h3FF0000030000000, 2'b00, 4'b0, 1'b0, 32'h3F800002, 64'h3FF0000040000000, 7'b0011010);
    run("R2 above half near", 64'h3FF0000010000001, 2'b00, 4'b0, 1'b0, 32'h3F800001, 64'h3FF0000020000000, 7'b0011010);
    run("R4 carry to two", 64'h3FFFFFFFFFFFFFFF, 2'b00, 4'b0, 1'b0, 32'h40000000, 64'h4000000000000000, 7'b0011010);
  endtask

  task automatic t_overflow;
    run("R4 carry ovf near", 64'h47EFFFFFFFFFFFFF, 2'b00, 4'b0, 1'b0, 32'h7F800000, 64'h7FF0000000000000, 7'b0110010);
    run("R4 max zero", 64'h47EFFFFFFFFFFFFF, 2'b01, 4'b0, 1'b0, 32'h7F7FFFFF, 64'h47EFFFFFE0000000, 7'b0010010);
    run("R5 huge near trap R12", 64'h47F0000000000000, 2'b00, 4'b0100, 1'b0, 32'h7F800000, 64'h7FF0000000000000, 7'b0110011);
    run("R5 huge zero", 64'h47F0000000000000, 2'b01, 4'b0, 1'b0, 32'h7F7FFFFF, 64'h47EFFFFFE0000000, 7'b0110010);
    run("R5 neg huge +inf", 64'hC7F0000000000000, 2'b10, 4'b0, 1'b0, 32'hFF7FFFFF, 64'hC7EFFFFFE0000000, 7'b0110010);
    run("R5 neg huge -inf", 64'hC7F0000000000000, 2'b11, 4'b0, 1'b0, 32'hFF800000, 64'hFFF0000000000000, 7'b0110010);
    run("R5 top exp zero", 64'h7FEFFFFFFFFFFFFF, 2'b01, 4'b0, 1'b0, 32'h7F7FFFFF, 64'h47EFFFFFE0000000, 7'b0110010);
  endtask

  task automatic t_tiny;
    run("R6 min denorm exact", 64'h36A0000000000000, 2'b00, 4'b0, 1'b0, 32'h00000001, 64'h36A0000000000000, 7'b0000000);
    run("R7 exact tiny ue", 64'h36A0000000000000, 2'b00, 4'b1000, 1'b0, 32'h00000001, 64'h36A0000000000000, 7'b1000001);
    run("R6 half ulp near", 64'h3690000000000000, 2'b00, 4'b0, 1'b0, 32'h00000000, 64'h0000000000000000, 7'b1010010);
    run("R7 half ulp +inf", 64'h3690000000000000, 2'b10, 4'b0, 1'b0, 32'h00000001, 64'h36A0000000000000, 7'b1011010);
    run("R6 dp denorm +inf", 64'h0000000000000001, 2'b10, 4'b0, 1'b0, 32'h00000001, 64'h36A0000000000000, 7'b1011010);
    run("R6 dp denorm near", 64'h0000000000000001, 2'b00, 4'b0, 1'b0, 32'h00000000, 64'h0000000000000000, 7'b1010010);
    run("R6 neg dp denorm -inf", 64'h8000000000000001, 2'b11, 4'b0, 1'b0, 32'h80000001, 64'hB6A0000000000000, 7'b1011010);
    run("R6 carry to normal", 64'h380FFFFFE0000000, 2'b00, 4'b0, 1'b0, 32'h00800000, 64'h3810000000000000, 7'b1011010);
    run("R13 denorm trunc", 64'h380FFFFFE0000000, 2'b01, 4'b0, 1'b0, 32'h007FFFFF, 64'h380FFFFFC0000000, 7'b1010010);
    run("R6 exact 2^-127", 64'h3800000000000000, 2'b00, 4'b0, 1'b0, 32'h00400000, 64'h3800000000000000, 7'b0000000);
    run("R6 lowest normal", 64'h3810000000000000, 2'b00, 4'b1000, 1'b0, 32'h00800000, 64'h3810000000000000, 7'b0000000);
  endtask

  task automatic t_special;
    run("R8 neg zero", 64'h8000000000000000, 2'b00, 4'b0, 1'b0, 32'h80000000, 64'h8000000000000000, 7'b0000000);
    run("R8 neg inf", 64'hFFF0000000000000, 2'b10, 4'b0, 1'b0, 32'hFF800000, 64'hFFF0000000000000, 7'b0000000);
    run("R9 qnan low bits", 64'h7FF8000000000001, 2'b00, 4'b1111, 1'b0, 32'h7FC00000, 64'h7FF8000000000000, 7'b0000000);
    run("R9 neg qnan", 64'hFFFC000000000000, 2'b00, 4'b0, 1'b0, 32'hFFE00000, 64'hFFFC000000000000, 7'b0000000);
    run("R10 snan trap R12", 64'h7FF0000020000000, 2'b00, 4'b0010, 1'b0, 32'h7FC00001, 64'h7FF8000020000000, 7'b0000101);
    run("R10 snan no trap", 64'h7FF0000020000000, 2'b00, 4'b0, 1'b0, 32'h7FC00001, 64'h7FF8000020000000, 7'b0000100);
  endtask

  task automatic t_sticky_trap;
    run("R11 sticky passes", 64'h3FF0000000000000, 2'b00, 4'b0, 1'b1, 32'h3F800000, 64'h3FF0000000000000, 7'b0000010);
    run("R12 inexact trap", 64'h3FF0000010000000, 2'b00, 4'b0001, 1'b0, 32'h3F800000, 64'h3FF0000000000000, 7'b0010011);
    run("R12 exact no trap", 64'h3FF0000000000000, 2'b00, 4'b1111, 1'b0, 32'h3F800000, 64'h3FF0000000000000, 7'b0000000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_round_modes();
    t_overflow();
    t_tiny();
    t_special();
    t_sticky_trap();
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule